// File: doc/BRIEF.md
# E1 Timeslot-0 National Bit Multiplexer

This block handles the five national bits (Sa4 to Sa8) carried in timeslot 0 of E1 frames that are not frame-alignment frames. On the transmit side it builds the timeslot-0 bit stream one bit at a time. For each national bit position, a 2-bit selector picks the source: a bit from a software-loaded national data word, a serial datalink input, the matching bit of backplane channel 0, or a per-position HDLC bit interface. In frame-alignment frames the backplane channel-0 byte passes through untouched.

On the receive side the block shifts in the incoming timeslot-0 byte. It always forwards that byte to the backplane, and at the end of each non-alignment timeslot 0 it latches the five received national bits into a receive buffer. Positions in datalink mode mirror their received bit on a serial datalink output, under a strobe that also paces the transmit datalink input. Positions in HDLC mode hand their received bit to the HDLC interface once per frame. Frame alignment, CRC-4 and HDLC framing are handled elsewhere. That outside logic supplies the timeslot-0 start pulse, the bit-rate tick and the frame-type flag.

Top module: `e1NatBitMux`

## Requirements
- R1: After reset every output is 0, including the receive national buffer, the received byte and the HDLC receive bits.
- R2: A timeslot 0 occupies eight bit periods. Each bit period is one clock cycle with `bitTick` high. The first of them is the tick that coincides with `ts0Start`. Cycles without `bitTick` are idle and move nothing. `txLineValid` is high exactly on the eight processing cycles, and bits go out MSB first (bit 7 first).
- R3: The frame type is taken from `nfasFrame` on the first bit period and held for the whole timeslot. In a frame-alignment frame (`nfasFrame`=0) the transmitted byte equals `bpChan0`.
- R4: In a non-alignment frame, transmit bit 6 is 1, and bits 7 and 5 come from the same bit positions of `bpChan0`.
- R5: In a non-alignment frame, Sa(4+i) for i=0..4 is sent in byte bit 4-i. Its source is chosen by `selCfg[2i+1:2i]`: 00 gives `txNatReg[i]`, 01 gives `txDlIn` sampled in that bit period, 10 gives `bpChan0[4-i]`, and 11 gives `hdlcTxBits[i]`.
- R6: `dlStrobe` is high on a bit period exactly when the frame is non-alignment, the bit is a national bit, and its selector is 01.
- R7: `rxDlOut` equals `rxLineBit` while `dlStrobe` is high and is 0 otherwise.
- R8: One cycle after the last bit period of every timeslot 0, `rxTs0Valid` pulses for one cycle and `rxTs0Byte` holds the received byte (first bit received in bit 7).
- R9: After a non-alignment timeslot 0, `rxNatBuf[i]` holds the received Sa(4+i), whatever the selectors say. After an alignment timeslot 0 the buffer does not change.
- R10: After a non-alignment timeslot 0, `hdlcRxStrobe` pulses together with `rxTs0Valid`. `hdlcRxMask[i]` is 1 when selector i is 11, and `hdlcRxBits[i]` is the received Sa(4+i) where the mask is 1 and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ts0Start | input | 1 | Marks the first bit period of timeslot 0 (with bitTick) |
| bitTick | input | 1 | One bit period is processed on this cycle |
| nfasFrame | input | 1 | 1 = non-alignment frame, sampled on the first bit period |
| selCfg | input | 10 | Five 2-bit source selectors, Sa4 in bits 1:0 |
| txNatReg | input | 5 | National data word, bit i for Sa(4+i) |
| txDlIn | input | 1 | Serial transmit datalink input |
| bpChan0 | input | 8 | Backplane channel-0 byte for this frame |
| hdlcTxBits | input | 5 | HDLC transmit bit per position |
| rxLineBit | input | 1 | Received timeslot-0 bit for this bit period |
| txLineBit | output | 1 | Transmit timeslot-0 bit for this bit period |
| txLineValid | output | 1 | High on processing cycles |
| dlStrobe | output | 1 | Datalink bit period strobe |
| rxDlOut | output | 1 | Serial receive datalink output |
| rxTs0Byte | output | 8 | Received timeslot-0 byte toward the backplane |
| rxTs0Valid | output | 1 | Pulse when rxTs0Byte updates |
| rxNatBuf | output | 5 | Receive national buffer, bit i = Sa(4+i) |
| hdlcRxBits | output | 5 | Received Sa bits for positions in HDLC mode |
| hdlcRxMask | output | 5 | Positions in HDLC mode |
| hdlcRxStrobe | output | 1 | Pulse when HDLC receive bits update |

## Verification
The bench inserts idle cycles between bit ticks at random. A design that advanced its bit counter on the clock instead of the tick would then send the wrong bit positions. It toggles `nfasFrame` in the middle of a timeslot. A design that read the flag on every bit instead of latching it would mix alignment and non-alignment behaviour inside one byte. It also runs alignment frames between non-alignment frames. A design that updated the receive buffer on every frame would overwrite the buffer with alignment-word bits. Finally, it drives every selector value on every position with random data, so that a reversed bit mapping for backplane mode, or a datalink strobe raised outside mode 01, shows up as a wrong transmitted bit or a wrong strobe.

// File: rtl/e1NatBitPkg.sv
package e1NatBitPkg;
  localparam int BYTE_W = 8;
  localparam int NUM_SA = 5;
  localparam int SLOT_W = $clog2(BYTE_W);
  localparam int FIRST_SA_SLOT = BYTE_W - NUM_SA;
  localparam int MARK_SLOT = 1;

  typedef enum logic [1:0] {
    SRC_NATREG = 2'b00,
    SRC_DLINK  = 2'b01,
    SRC_BPLANE = 2'b10,
    SRC_HDLC   = 2'b11
  } saSrcE;

  typedef struct packed {
    logic              bitEn;
    logic [SLOT_W-1:0] slot;
    logic              nfas;
    logic              lastBit;
  } ts0StrobeT;
endpackage

// File: rtl/e1NatBitCtrl.sv
module e1NatBitCtrl
  import e1NatBitPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ts0Start,
  input  logic      bitTick,
  input  logic      nfasFrame,
  output ts0StrobeT stb
);
  logic              inTs0;
  logic [SLOT_W-1:0] slotCnt;
  logic              nfasLat;
  logic              startNow;
  logic [SLOT_W-1:0] curSlot;
  logic              curNfas;
  logic              curActive;

  assign startNow  = ts0Start & bitTick;
  assign curActive = startNow | inTs0;
  assign curSlot   = startNow ? '0 : slotCnt;
  assign curNfas   = startNow ? nfasFrame : nfasLat;

  always_comb begin
    stb.bitEn   = bitTick & curActive;
    stb.slot    = curSlot;
    stb.nfas    = curNfas;
    stb.lastBit = bitTick & curActive & (curSlot == SLOT_W'(BYTE_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inTs0   <= 1'b0;
      slotCnt <= '0;
      nfasLat <= 1'b0;
    end else if (bitTick && curActive) begin
      nfasLat <= curNfas;
      if (curSlot == SLOT_W'(BYTE_W - 1)) begin
        inTs0   <= 1'b0;
        slotCnt <= '0;
      end else begin
        inTs0   <= 1'b1;
        slotCnt <= curSlot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/e1NatBitPath.sv
module e1NatBitPath
  import e1NatBitPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ts0StrobeT           stb,
  input  logic [2*NUM_SA-1:0] selCfg,
  input  logic [NUM_SA-1:0]   txNatReg,
  input  logic                txDlIn,
  input  logic [BYTE_W-1:0]   bpChan0,
  input  logic [NUM_SA-1:0]   hdlcTxBits,
  input  logic                rxLineBit,
  output logic                txLineBit,
  output logic                dlStrobe,
  output logic                rxDlOut,
  output logic [BYTE_W-1:0]   rxTs0Byte,
  output logic                rxTs0Valid,
  output logic [NUM_SA-1:0]   rxNatBuf,
  output logic [NUM_SA-1:0]   hdlcRxBits,
  output logic [NUM_SA-1:0]   hdlcRxMask,
  output logic                hdlcRxStrobe
);
  localparam int IDX_W = $clog2(NUM_SA);

  logic              isSa;
  logic [IDX_W-1:0]  saIdx;
  logic [SLOT_W-1:0] bitPos;
  logic              bpBit;
  saSrcE             curSel;
  logic              srcBit;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] rxFull;
  logic [NUM_SA-1:0] hdlcSelMask;
  logic [NUM_SA-1:0] rxSaBits;

  assign isSa   = (stb.slot >= SLOT_W'(FIRST_SA_SLOT));
  assign saIdx  = IDX_W'(stb.slot - SLOT_W'(FIRST_SA_SLOT));
  assign bitPos = SLOT_W'(BYTE_W - 1) - stb.slot;
  assign bpBit  = bpChan0[bitPos];
  assign curSel = saSrcE'(selCfg[2*saIdx +: 2]);

  always_comb begin
    unique case (curSel)
      SRC_NATREG: srcBit = txNatReg[saIdx];
      SRC_DLINK:  srcBit = txDlIn;
      SRC_BPLANE: srcBit = bpBit;
      SRC_HDLC:   srcBit = hdlcTxBits[saIdx];
      default:    srcBit = 1'b0;
    endcase
  end

  always_comb begin
    if (!stb.bitEn)                             txLineBit = 1'b0;
    else if (!stb.nfas)                         txLineBit = bpBit;
    else if (stb.slot == SLOT_W'(MARK_SLOT))    txLineBit = 1'b1;
    else if (isSa)                              txLineBit = srcBit;
    else                                        txLineBit = bpBit;
  end

  assign dlStrobe = stb.bitEn & stb.nfas & isSa & (curSel == SRC_DLINK);
  assign rxDlOut  = dlStrobe & rxLineBit;
  assign rxFull   = {rxShift[BYTE_W-2:0], rxLineBit};

  for (genvar i = 0; i < NUM_SA; i++) begin : g_sa
    assign hdlcSelMask[i] = (selCfg[2*i +: 2] == SRC_HDLC);
    assign rxSaBits[i]    = rxFull[NUM_SA-1-i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift      <= '0;
      rxTs0Byte    <= '0;
      rxTs0Valid   <= 1'b0;
      rxNatBuf     <= '0;
      hdlcRxBits   <= '0;
      hdlcRxMask   <= '0;
      hdlcRxStrobe <= 1'b0;
    end else begin
      rxTs0Valid   <= 1'b0;
      hdlcRxStrobe <= 1'b0;
      if (stb.bitEn) rxShift <= rxFull;
      if (stb.lastBit) begin
        rxTs0Byte  <= rxFull;
        rxTs0Valid <= 1'b1;
        if (stb.nfas) begin
          rxNatBuf     <= rxSaBits;
          hdlcRxMask   <= hdlcSelMask;
          hdlcRxBits   <= rxSaBits & hdlcSelMask;
          hdlcRxStrobe <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/e1NatBitMux.sv
module e1NatBitMux
  import e1NatBitPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ts0Start,
  input  logic                bitTick,
  input  logic                nfasFrame,
  input  logic [2*NUM_SA-1:0] selCfg,
  input  logic [NUM_SA-1:0]   txNatReg,
  input  logic                txDlIn,
  input  logic [BYTE_W-1:0]   bpChan0,
  input  logic [NUM_SA-1:0]   hdlcTxBits,
  input  logic                rxLineBit,
  output logic                txLineBit,
  output logic                txLineValid,
  output logic                dlStrobe,
  output logic                rxDlOut,
  output logic [BYTE_W-1:0]   rxTs0Byte,
  output logic                rxTs0Valid,
  output logic [NUM_SA-1:0]   rxNatBuf,
  output logic [NUM_SA-1:0]   hdlcRxBits,
  output logic [NUM_SA-1:0]   hdlcRxMask,
  output logic                hdlcRxStrobe
);
  ts0StrobeT stb;

  e1NatBitCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .ts0Start(ts0Start), .bitTick(bitTick),
    .nfasFrame(nfasFrame), .stb(stb)
  );

  e1NatBitPath u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .selCfg(selCfg),
    .txNatReg(txNatReg), .txDlIn(txDlIn), .bpChan0(bpChan0),
    .hdlcTxBits(hdlcTxBits), .rxLineBit(rxLineBit),
    .txLineBit(txLineBit), .dlStrobe(dlStrobe), .rxDlOut(rxDlOut),
    .rxTs0Byte(rxTs0Byte), .rxTs0Valid(rxTs0Valid), .rxNatBuf(rxNatBuf),
    .hdlcRxBits(hdlcRxBits), .hdlcRxMask(hdlcRxMask),
    .hdlcRxStrobe(hdlcRxStrobe)
  );

  assign txLineValid = stb.bitEn;
endmodule

// File: rtl/e1NatBitMuxChk.sv
module e1NatBitMuxChk
  import e1NatBitPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              bitTick,
  input logic              txLineValid,
  input logic              txLineBit,
  input logic              dlStrobe,
  input logic              rxDlOut,
  input logic              rxTs0Valid,
  input logic [NUM_SA-1:0] rxNatBuf,
  input logic [NUM_SA-1:0] hdlcRxBits,
  input logic [NUM_SA-1:0] hdlcRxMask,
  input logic              hdlcRxStrobe
);
  a_r2_valid_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    txLineValid |-> bitTick);
  a_r2_tx_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !txLineValid |-> !txLineBit);
  a_r6_strobe_in_ts0: assert property (@(posedge clk) disable iff (!rstN)
    dlStrobe |-> txLineValid);
  a_r7_rxdl_gated: assert property (@(posedge clk) disable iff (!rstN)
    !dlStrobe |-> !rxDlOut);
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxTs0Valid |=> !rxTs0Valid);
  a_r9_buf_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxNatBuf) |-> hdlcRxStrobe);
  a_r10_strobe_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    hdlcRxStrobe |-> rxTs0Valid);
  a_r10_bits_in_mask: assert property (@(posedge clk) disable iff (!rstN)
    (hdlcRxBits & ~hdlcRxMask) == '0);
endmodule

bind e1NatBitMux e1NatBitMuxChk u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .txLineValid(txLineValid),
  .txLineBit(txLineBit), .dlStrobe(dlStrobe), .rxDlOut(rxDlOut),
  .rxTs0Valid(rxTs0Valid), .rxNatBuf(rxNatBuf), .hdlcRxBits(hdlcRxBits),
  .hdlcRxMask(hdlcRxMask), .hdlcRxStrobe(hdlcRxStrobe)
);

// File: tb/e1NatBitMux_bench.sv
module e1NatBitMux_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ts0Start = 1'b0, bitTick = 1'b0, nfasFrame = 1'b0;
  logic [9:0] selCfg = '0;
  logic [4:0] txNatReg = '0, hdlcTxBits = '0;
  logic       txDlIn = 1'b0, rxLineBit = 1'b0;
  logic [7:0] bpChan0 = '0;
  logic       txLineBit, txLineValid, dlStrobe, rxDlOut, rxTs0Valid, hdlcRxStrobe;
  logic [7:0] rxTs0Byte;
  logic [4:0] rxNatBuf, hdlcRxBits, hdlcRxMask;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [4:0] expBuf = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1NatBitMux u_e1NatBitMux (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expTx(int slot, bit nfas, logic [9:0] sel,
      logic [4:0] nat, logic dl, logic [7:0] bp, logic [4:0] hd);
    int b = 7 - slot;
    int i = slot - 3;
    if (!nfas) return bp[b];
    if (slot == 1) return 1'b1;
    if (slot < 3) return bp[b];
    case (sel[2*i +: 2])
      2'b00: return nat[i];
      2'b01: return dl;
      2'b10: return bp[b];
      default: return hd[i];
    endcase
  endfunction

  task automatic runFrame(bit nfas, logic [7:0] rxByte, bit gaps);
    @(negedge clk);
    selCfg = 10'($urandom); txNatReg = 5'($urandom);
    bpChan0 = 8'($urandom); hdlcTxBits = 5'($urandom);
    for (int s = 0; s < 8; s++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        bitTick = 1'b0; ts0Start = 1'b0; nfasFrame = 1'($urandom);
        #1 chk("R2 idle valid", 32'(txLineValid), 0);
        @(negedge clk);
      end
      bitTick = 1'b1; ts0Start = (s == 0);
      nfasFrame = (s == 0) ? nfas : 1'($urandom);
      txDlIn = 1'($urandom); rxLineBit = rxByte[7-s];
      #1;
      chk("R2 valid", 32'(txLineValid), 1);
      chk((s == 1 && nfas) ? "R4 marker" : (s >= 3 ? "R5 tx bit" : "R3 tx bit"),
          32'(txLineBit), 32'(expTx(s, nfas, selCfg, txNatReg, txDlIn, bpChan0, hdlcTxBits)));
      begin
        bit st = nfas && s >= 3 && selCfg[2*(s-3) +: 2] == 2'b01;
        chk("R6 dlStrobe", 32'(dlStrobe), 32'(st));
        chk("R7 rxDlOut", 32'(rxDlOut), 32'(st & rxLineBit));
      end
      @(negedge clk);
    end
    bitTick = 1'b0; ts0Start = 1'b0;
    #1;
    chk("R8 valid", 32'(rxTs0Valid), 1);
    chk("R8 byte", 32'(rxTs0Byte), 32'(rxByte));
    if (nfas) for (int i = 0; i < 5; i++) expBuf[i] = rxByte[4-i];
    chk("R9 buffer", 32'(rxNatBuf), 32'(expBuf));
    chk("R10 strobe", 32'(hdlcRxStrobe), 32'(nfas));
    if (nfas) begin
      logic [4:0] m;
      for (int i = 0; i < 5; i++) m[i] = (selCfg[2*i +: 2] == 2'b11);
      chk("R10 mask", 32'(hdlcRxMask), 32'(m));
      chk("R10 bits", 32'(hdlcRxBits), 32'(m & expBuf));
    end
    @(negedge clk); #1;
    chk("R8 pulse end", 32'(rxTs0Valid), 0);
  endtask

  initial begin
    void'($urandom(32'd1907));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset buf", 32'(rxNatBuf), 0);
    chk("R1 reset byte", 32'(rxTs0Byte), 0);
    chk("R1 reset hdlc", 32'({hdlcRxBits, hdlcRxMask, hdlcRxStrobe, rxTs0Valid}), 0);
    chk("R1 reset tx", 32'({txLineBit, txLineValid, dlStrobe, rxDlOut}), 0);
    rstN = 1'b1;
    // directed: tick without start does nothing (R2)
    @(negedge clk); bitTick = 1'b1; #1;
    chk("R2 no start", 32'(txLineValid), 0);
    @(negedge clk); bitTick = 1'b0;
    runFrame(1'b1, 8'h5A, 1'b0);
    runFrame(1'b0, 8'hFF, 1'b0);   // R9 alignment frame keeps buffer
    runFrame(1'b1, 8'h00, 1'b1);
    runFrame(1'b1, 8'h1F, 1'b1);
    for (int f = 0; f < 300; f++)
      runFrame(1'($urandom % 4 != 0), 8'($urandom), 1'($urandom));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule